// File: doc/BRIEF.md
# Software-Restarted Watchdog Countdown

This block is a watchdog timer that software drives through a small word-addressed register window on a 32-bit bus. Software programs a start value, turns counting on through a control word, and keeps the countdown alive by writing a 16-bit key into a dedicated restart slot. Any other value written there does nothing. When the count runs out, the block emits a single-cycle expiry pulse and then stops counting. A restart or a fresh enable starts it again.

Each decrement is triggered by one of two tick sources, chosen by a control bit. One is the block's own clock, which is the fast peripheral clock. The other is a slower tick made by dividing that clock with a prescaler. With the default divider of 24 and a 24 MHz clock, the slow tick is 1 MHz. Control bits route the expiry pulse to separate outputs: a reset request, an interrupt, an external signal, and a qualifier that asks for a whole-chip reset rather than a partial one.

The control word is changed only by a write that flips the enable bit. A write that leaves the enable bit as it is has no effect at all, even on the other control fields.

Top module: `mmio_watchdog`

## Requirements
- R1: After reset, the counter (offset 0x00) and the reload register (offset 0x04) both read 0x03EF1480, and the control word (offset 0x0C) reads 0, so counting is off.
- R2: A read of an aligned offset returns the following. Offset 0x00 gives the live counter. Offset 0x04 gives the reload value and is read/write. Offset 0x0C gives the control word in bits 5:0, with zeros above. Offsets 0x08, 0x10, 0x14 and 0x18, and any offset above 0x18, read as zero.
- R3: Writes to 0x00, 0x10, 0x14 and 0x18, to offsets above 0x18, and to any offset whose two low bits are not zero change no readable state.
- R4: A write to 0x08 whose bits 15:0 equal 0x4755 copies the reload value into the counter, whatever the upper 16 bits hold. The counter then counts again from that value when enabled, even after an expiry.
- R5: A write to 0x08 whose bits 15:0 differ from 0x4755 leaves the counter unchanged.
- R6: A write to 0x0C is stored only when its bit 0 differs from the stored enable bit. Otherwise the whole control word is kept.
- R7: When enable goes from 0 to 1, the counter is loaded from the reload register and counting starts. When enable goes from 1 to 0, the counter holds its value.
- R8: With control bit 4 clear, the counter decrements on every clock. After enabling with reload value N, the expiry pulse appears N cycles after the enabling write.
- R9: With control bit 4 set, the counter decrements once every TICK_DIV clocks, and the prescaler restarts whenever the counter is loaded. The expiry then appears N*TICK_DIV cycles after the load.
- R10: On expiry, the counter reads 0. The expiry pulse lasts one cycle, and no further pulse occurs until the counter is loaded again.
- R11: The expiry pulse drives each output whose control bit is set: reset request for bit 1, interrupt for bit 2, external signal for bit 3. The whole-chip qualifier pulses when both bit 5 and bit 1 are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock, also the fast tick |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rst_req_o | output | 1 | Reset-request expiry pulse |
| irq_o | output | 1 | Interrupt expiry pulse |
| ext_o | output | 1 | External-signal expiry pulse |
| full_chip_o | output | 1 | Whole-chip qualifier for the reset request |

## Verification
The assertions check the following on every cycle. A disabled counter holds its value. A fast-mode count steps down by exactly one. A slow-mode count never steps by more than one. A key write loads the reload value. A control write that repeats the enable bit leaves the control word alone. Any expiry output coincides with a zero count. Only the bench scenarios can show the exact expiry cycle for each tick source, the read values across the register window, and the rejection of wrong keys and misaligned writes. They also show the absence of a second pulse after halting and the routing of a pulse to the right outputs.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int unsigned REG_W = 32;
    localparam int unsigned CTRL_W = 6;
    localparam logic [15:0] KICK_KEY = 16'h4755;

    // byte offsets inside the register window
    localparam int unsigned OFS_COUNT  = 'h00;
    localparam int unsigned OFS_RELOAD = 'h04;
    localparam int unsigned OFS_KICK   = 'h08;
    localparam int unsigned OFS_CTRL   = 'h0C;

    // control word bit positions
    localparam int unsigned CB_EN   = 0;
    localparam int unsigned CB_RST  = 1;
    localparam int unsigned CB_IRQ  = 2;
    localparam int unsigned CB_EXT  = 3;
    localparam int unsigned CB_SLOW = 4;
    localparam int unsigned CB_FULL = 5;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [REG_W-1:0]  reload;
    } regs_t;

    typedef struct packed {
        logic [REG_W-1:0] cnt;
        logic             halted;
        logic             expire;
    } cd_t;
endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
    import wdt_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter logic [31:0] RELOAD_INIT = 32'h03EF1480
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    input  logic [REG_W-1:0]    cnt_i,
    output logic [REG_W-1:0]    rdata_o,
    output logic [CTRL_W-1:0]   ctrl_o,
    output logic [REG_W-1:0]    reload_o,
    output logic                load_o
);
    regs_t st_d, st_q;
    logic  aligned, wr, rd;
    logic  hit_count, hit_reload, hit_kick, hit_ctrl;
    logic  en_new, rise;

    always_comb begin
        aligned    = (bus_addr[1:0] == 2'b00);
        wr         = bus_valid && bus_write && aligned;
        rd         = bus_valid && !bus_write && aligned;
        hit_count  = (bus_addr == ADDR_W'(OFS_COUNT));
        hit_reload = (bus_addr == ADDR_W'(OFS_RELOAD));
        hit_kick   = (bus_addr == ADDR_W'(OFS_KICK));
        hit_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
        en_new     = bus_wdata[CB_EN];

        st_d = st_q;
        if (wr && hit_reload) begin
            st_d.reload = bus_wdata;
        end
        if (wr && hit_ctrl && (en_new != st_q.ctrl[CB_EN])) begin
            st_d.ctrl = bus_wdata[CTRL_W-1:0];
        end

        rise   = wr && hit_ctrl && en_new && !st_q.ctrl[CB_EN];
        load_o = rise || (wr && hit_kick && (bus_wdata[15:0] == KICK_KEY));

        rdata_o = '0;
        if (rd) begin
            if (hit_count) begin
                rdata_o = cnt_i;
            end else if (hit_reload) begin
                rdata_o = st_q.reload;
            end else if (hit_ctrl) begin
                rdata_o = REG_W'(st_q.ctrl);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl   <= '0;
            st_q.reload <= RELOAD_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o   = st_q.ctrl;
    assign reload_o = st_q.reload;
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int unsigned TICK_DIV = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_i,
    input  logic clear_i,
    output logic tick_o
);
    generate
        if (TICK_DIV < 2) begin : g_pass
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int unsigned PW = $clog2(TICK_DIV);
            localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
            logic [PW-1:0] pre_d, pre_q;
            logic          wrap;

            always_comb begin
                wrap  = (pre_q == LAST);
                pre_d = '0;
                if (!clear_i && slow_i && !wrap) begin
                    pre_d = pre_q + 1'b1;
                end
                tick_o = slow_i ? wrap : 1'b1;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_d;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
    import wdt_pkg::*;
#(
    parameter logic [31:0] CNT_INIT = 32'h03EF1480
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [REG_W-1:0] load_val_i,
    input  logic             run_i,
    input  logic             tick_i,
    output logic [REG_W-1:0] cnt_o,
    output logic             expire_o
);
    cd_t cd_d, cd_q;

    always_comb begin
        cd_d        = cd_q;
        cd_d.expire = 1'b0;
        if (load_i) begin
            cd_d.cnt    = load_val_i;
            cd_d.halted = 1'b0;
        end else if (run_i && !cd_q.halted && tick_i) begin
            if (cd_q.cnt <= REG_W'(1)) begin
                cd_d.cnt    = '0;
                cd_d.halted = 1'b1;
                cd_d.expire = 1'b1;
            end else begin
                cd_d.cnt = cd_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cd_q.cnt    <= CNT_INIT;
            cd_q.halted <= 1'b0;
            cd_q.expire <= 1'b0;
        end else begin
            cd_q <= cd_d;
        end
    end

    assign cnt_o    = cd_q.cnt;
    assign expire_o = cd_q.expire;
endmodule

// File: rtl/mmio_watchdog.sv
module mmio_watchdog
    import wdt_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned TICK_DIV   = 24,
    parameter logic [31:0] RESET_LOAD = 32'h03EF1480
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              rst_req_o,
    output logic              irq_o,
    output logic              ext_o,
    output logic              full_chip_o
);
    logic [CTRL_W-1:0] ctrl_w;
    logic [REG_W-1:0]  reload_w, cnt_w;
    logic              load_w, tick_w, expire_w;

    wdt_regfile #(.ADDR_W(ADDR_W), .RELOAD_INIT(RESET_LOAD)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .cnt_i(cnt_w), .rdata_o(bus_rdata),
        .ctrl_o(ctrl_w), .reload_o(reload_w), .load_o(load_w)
    );

    wdt_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n),
        .slow_i(ctrl_w[CB_SLOW]), .clear_i(load_w), .tick_o(tick_w)
    );

    wdt_countdown #(.CNT_INIT(RESET_LOAD)) u_cd (
        .clk(clk), .rst_n(rst_n),
        .load_i(load_w), .load_val_i(reload_w),
        .run_i(ctrl_w[CB_EN]), .tick_i(tick_w),
        .cnt_o(cnt_w), .expire_o(expire_w)
    );

    always_comb begin
        rst_req_o   = expire_w && ctrl_w[CB_RST];
        irq_o       = expire_w && ctrl_w[CB_IRQ];
        ext_o       = expire_w && ctrl_w[CB_EXT];
        full_chip_o = expire_w && ctrl_w[CB_RST] && ctrl_w[CB_FULL];
    end
endmodule

// File: rtl/wdt_props.sv
module wdt_props
    import wdt_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       wd_lo,
    input logic [CTRL_W-1:0] ctrl,
    input logic [REG_W-1:0]  cnt,
    input logic [REG_W-1:0]  reload,
    input logic              load,
    input logic              rst_req_o,
    input logic              irq_o,
    input logic              ext_o
);
    assert_key_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == ADDR_W'(OFS_KICK) && wd_lo == KICK_KEY)
        |=> cnt == $past(reload));

    assert_ctrl_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == ADDR_W'(OFS_CTRL) && wd_lo[0] == ctrl[CB_EN])
        |=> $stable(ctrl));

    assert_off_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[CB_EN] && !load) |=> cnt == $past(cnt));

    assert_fast_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[CB_EN] && !ctrl[CB_SLOW] && !load && cnt > 32'd1)
        |=> cnt == $past(cnt) - 32'd1);

    assert_slow_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[CB_EN] && ctrl[CB_SLOW] && !load && cnt != 32'd0)
        |=> (cnt == $past(cnt) || cnt == $past(cnt) - 32'd1));

    assert_pulse_at_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_o || irq_o || ext_o) |-> cnt == 32'd0);
endmodule

bind mmio_watchdog wdt_props #(.ADDR_W(ADDR_W)) u_props (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .wd_lo(bus_wdata[15:0]),
    .ctrl(ctrl_w), .cnt(cnt_w), .reload(reload_w), .load(load_w),
    .rst_req_o(rst_req_o), .irq_o(irq_o), .ext_o(ext_o)
);

// File: tb/sim_mmio_watchdog.sv
module sim_mmio_watchdog;
    localparam int AW  = 8;
    localparam int DIV = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          rst_req_o, irq_o, ext_o, full_chip_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    typedef struct { int at; logic [3:0] pv; string req; } pulse_t;
    typedef struct { logic [31:0] val; string req; } rd_t;
    pulse_t exp_pulse[$];
    rd_t    exp_rd[$];

    mmio_watchdog #(.ADDR_W(AW), .TICK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req_o(rst_req_o), .irq_o(irq_o), .ext_o(ext_o), .full_chip_o(full_chip_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // monitor: compares outputs against queued expectations
    always @(negedge clk) begin
        pulse_t      p;
        rd_t         r;
        logic [3:0]  pv;
        if (rst_n) begin
            pv = {full_chip_o, ext_o, irq_o, rst_req_o};
            if (pv != 4'b0) begin
                if (exp_pulse.size() == 0) begin
                    chk(1'b0, "R10 unexpected pulse", {cyc[27:0], pv}, 32'h0);
                end else begin
                    p = exp_pulse.pop_front();
                    chk(cyc == p.at && pv == p.pv, p.req, {cyc[27:0], pv}, {p.at[27:0], p.pv});
                end
            end
            if (bus_valid && !bus_write) begin
                if (exp_rd.size() == 0) begin
                    chk(1'b0, "R2 unqueued read", bus_rdata, 32'h0);
                end else begin
                    r = exp_rd.pop_front();
                    chk(bus_rdata == r.val, r.req, bus_rdata, r.val);
                end
            end
        end
    end

    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(posedge clk);
        #1 bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
        rd_t r;
        r.val = exp;
        r.req = req;
        @(posedge clk);
        #1 exp_rd.push_back(r);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(posedge clk);
        #1 bus_valid = 1'b0;
    endtask

    // called right after the write whose edge starts the count
    task automatic expect_pulse(input int n_after, input logic [3:0] pv, input string req);
        pulse_t p;
        p.at  = cyc + n_after;
        p.pv  = pv;
        p.req = req;
        exp_pulse.push_back(p);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog timeout actual=hung expected=finish");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        bus_rd('h00, 32'h03EF1480, "R1 counter reset");
        bus_rd('h04, 32'h03EF1480, "R1 reload reset");
        bus_rd('h0C, 32'h0, "R1 control reset");

        // R2 zero-reading offsets
        bus_rd('h08, 32'h0, "R2 restart reads zero");
        bus_rd('h10, 32'h0, "R2 0x10 reads zero");
        bus_rd('h14, 32'h0, "R2 0x14 reads zero");
        bus_rd('h18, 32'h0, "R2 0x18 reads zero");
        bus_rd('h40, 32'h0, "R2 out of range reads zero");
        bus_wr('h04, 32'd5);
        bus_rd('h04, 32'd5, "R2 reload readback");

        // R3 ignored writes
        bus_wr('h00, 32'h77);
        bus_rd('h00, 32'h03EF1480, "R3 counter write ignored");
        bus_wr('h05, 32'd9);
        bus_wr('h18, 32'hFF);
        bus_wr('h50, 32'h1);
        bus_rd('h04, 32'd5, "R3 misaligned/unimpl write ignored");
        bus_rd('h0C, 32'h0, "R3 control untouched");

        // R5 wrong keys
        bus_wr('h08, 32'h0000_4756);
        bus_rd('h00, 32'h03EF1480, "R5 wrong key ignored");
        bus_wr('h08, 32'h4755_0000);
        bus_rd('h00, 32'h03EF1480, "R5 key in upper half ignored");

        // R4 key with arbitrary upper bits
        bus_wr('h08, 32'hABCD_4755);
        bus_rd('h00, 32'd5, "R4 key loads counter");

        // R6 write that repeats enable=0
        bus_wr('h0C, 32'h3E);
        bus_rd('h0C, 32'h0, "R6 repeated disable ignored");

        // R8 fast tick expiry, reset routing
        bus_wr('h0C, 32'h03);
        expect_pulse(5, 4'b0001, "R8 fast expiry");
        repeat (12) @(posedge clk);
        bus_rd('h00, 32'h0, "R10 counter zero after expiry");
        repeat (10) @(posedge clk);
        bus_rd('h00, 32'h0, "R10 counter halted");

        // R6 write that repeats enable=1
        bus_wr('h0C, 32'h17);
        bus_rd('h0C, 32'h03, "R6 repeated enable ignored");

        // R7 disable
        bus_wr('h0C, 32'h00);
        bus_rd('h0C, 32'h0, "R7 disable stored");

        // R9 slow tick expiry, interrupt routing
        bus_wr('h0C, 32'h15);
        expect_pulse(5 * DIV, 4'b0010, "R9 slow expiry");
        repeat (30) @(posedge clk);
        bus_rd('h0C, 32'h15, "R9 control readback");

        // R4 restart after halt
        bus_wr('h08, 32'h0000_4755);
        expect_pulse(5 * DIV, 4'b0010, "R4 restart resumes after halt");
        repeat (30) @(posedge clk);

        // R7 disable mid-count holds the value
        bus_wr('h08, 32'h0000_4755);
        bus_wr('h0C, 32'h00);
        bus_rd('h00, 32'd5, "R7 counter held at disable");
        repeat (40) @(posedge clk);
        bus_rd('h00, 32'd5, "R7 counter still held");

        // R11 routing to reset, external and whole-chip outputs
        bus_wr('h04, 32'd1);
        bus_wr('h0C, 32'h2B);
        expect_pulse(1, 4'b1101, "R11 routing rst/ext/full");
        repeat (5) @(posedge clk);
        bus_rd('h00, 32'h0, "R10 counter zero after short count");

        repeat (5) @(posedge clk);
        while (exp_pulse.size() != 0) begin
            pulse_t p;
            p = exp_pulse.pop_front();
            chk(1'b0, p.req, 32'h0, {p.at[27:0], p.pv});
        end
        report();
    end
endmodule